// File: doc/BRIEF.md
# SPI Frame Buffer Access Slave

This block is an SPI slave that lets an external host move a whole radio frame into or out of a 128-byte packet buffer in one transfer. A transfer starts when chip select goes low. The first byte the host shifts in is a command. A frame-write command is followed by a length byte and then the payload, which is stored in the buffer. A frame-read command makes the slave return the stored length, then the payload, then three quality bytes: link quality, energy level and receive status. Raising chip select ends the transfer and discards any command in progress.

On the chip side, a host port lets the receive logic write payload bytes into the buffer and set the length and the three quality values. The transmit logic reads the buffer through its own address port. It also gets a one-cycle strobe when the SPI host has finished writing a complete frame.

The SPI inputs are asynchronous to the system clock. They pass through two synchronizer stages and an edge detector. MISO therefore changes about three system clocks after a falling SCLK edge, so each SCLK half-period must last at least four system clocks. This means the system clock runs at least eight times faster than SCLK.

The controller has eight states, and raising chip select returns every state to idle:

| State | Meaning | Exits |
|---|---|---|
| IDLE | chip select is high | a chip-select fall goes to CMD |
| CMD | the command byte is being shifted in | a write opcode goes to WR_LEN, a read opcode goes to RD_LEN, anything else goes to DRAIN |
| WR_LEN | the length byte is arriving | the byte completes and goes to WR_DATA |
| WR_DATA | payload bytes are arriving | none until chip select rises |
| RD_LEN | the length byte is being sent | goes to RD_TRAIL if the length is zero, otherwise to RD_DATA |
| RD_DATA | payload bytes are being sent | after the last payload byte, goes to RD_TRAIL |
| RD_TRAIL | the three quality bytes are being sent | after the third, goes to DRAIN |
| DRAIN | any extra bytes are clocked | MISO sends zeros and nothing is stored |

Top module: `spi_frame_slave`

## Requirements
- R1: After reset, spi_miso, tx_ready and frm_len are all 0.
- R2: The SPI link uses mode 0, with the most significant bit first. MOSI is sampled on the rising SCLK edge and MISO changes on the falling edge. MISO carries 0x00 while the command byte is being shifted.
- R3: Bits 7:5 of the command byte select the access type: 3'b011 is frame write and 3'b001 is frame read. Bits 4:0 are ignored. Any other opcode stores nothing and changes neither the length nor the buffer. In every transfer that is not a frame read, MISO is 0x00 for every byte.
- R4: In a frame write, the second byte is stored as the frame length and appears on frm_len. Payload byte k is stored at buffer address k, and it can be read back on tx_rd_addr/tx_rd_data.
- R5: In a frame write, payload bytes at or beyond the declared length are discarded. Bytes at index 128 or higher are also discarded and never wrap to low addresses.
- R6: In a frame read, MISO sends the stored length in byte slot 1. It then sends payload addresses 0 to length-1 in order.
- R7: After the last payload byte of a frame read, the slave sends link quality, energy level and receive status, in that order. Every byte after those three is 0x00.
- R8: When chip select rises, including in the middle of a byte, the transfer ends. A partial byte is not stored, and the next transfer starts again from its command byte.
- R9: The host port writes a buffer byte when hst_buf_we is high. When hst_meta_we is high, it writes hst_wdata to a quality field selected by hst_meta_sel: 0 is the length, 1 is link quality, 2 is energy level and 3 is receive status.
- R10: tx_ready pulses for exactly one cycle after chip select rises on a frame write that delivered at least as many payload bytes as the declared length. It does not pulse for any other transfer.
- R11: A frame read of a zero-length frame sends the three quality bytes immediately after the length byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, asynchronous, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the SPI host |
| spi_miso | output | 1 | Serial data to the SPI host |
| hst_buf_we | input | 1 | Host-port buffer write strobe |
| hst_buf_addr | input | 7 | Host-port buffer write address |
| hst_meta_we | input | 1 | Host-port quality-field write strobe |
| hst_meta_sel | input | 2 | Field select: 0 length, 1 link quality, 2 energy, 3 status |
| hst_wdata | input | 8 | Host-port write data |
| tx_rd_addr | input | 7 | Buffer read address for the transmit side |
| tx_rd_data | output | 8 | Buffer byte at tx_rd_addr |
| frm_len | output | 8 | Current frame length |
| tx_ready | output | 1 | One-cycle strobe: a complete frame was written over SPI |

## Verification
The hardest case to reach is a transfer cut off partway through. The test must raise chip select in the middle of a byte, after some payload has already moved. It must then show that the partial byte was discarded, the ready strobe stayed low, and the next command was decoded from a fresh first byte.

The bench reaches this case with a transfer task that takes a count of extra loose bits to clock before raising chip select. It applies this to both a write and a read, and follows each with a normal read. The overflow case is reached by declaring a length of 200 and sending 130 payload bytes. The bench then checks that address 0 still holds payload byte 0 and not byte 128.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

    localparam int BYTE_W = 8;

    localparam logic [2:0] OP_FRAME_WR = 3'b011;
    localparam logic [2:0] OP_FRAME_RD = 3'b001;

    localparam logic [1:0] META_LEN  = 2'd0;
    localparam logic [1:0] META_LQI  = 2'd1;
    localparam logic [1:0] META_ED   = 2'd2;
    localparam logic [1:0] META_STAT = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR_LEN,
        ST_WR_DATA,
        ST_RD_LEN,
        ST_RD_DATA,
        ST_RD_TRAIL,
        ST_DRAIN
    } fsm_state_t;

endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_low,
    output logic mosi_s
);

    localparam int NEW = SYNC_STAGES - 1;
    localparam int OLD = SYNC_STAGES;

    logic [SYNC_STAGES:0]   sclk_q;
    logic [SYNC_STAGES:0]   cs_q;
    logic [SYNC_STAGES-1:0] mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[SYNC_STAGES-1:0], sclk_in};
            cs_q   <= {cs_q[SYNC_STAGES-1:0], cs_n_in};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi_in};
        end
    end

    assign sclk_rise = sclk_q[NEW] & ~sclk_q[OLD];
    assign sclk_fall = ~sclk_q[NEW] & sclk_q[OLD];
    assign cs_fall   = ~cs_q[NEW] & cs_q[OLD];
    assign cs_rise   = cs_q[NEW] & ~cs_q[OLD];
    assign cs_low    = ~cs_q[NEW];
    assign mosi_s    = mosi_q[NEW];

endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
    parameter  int BYTE_W = 8,
    localparam int CNT_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_done,
    output logic              miso
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [CNT_W-1:0]  bit_cnt;

    assign rx_byte   = {rx_sh, mosi_s};
    assign byte_done = cs_low && sclk_rise && (bit_cnt == LAST_BIT);
    assign miso      = tx_sh[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            tx_sh   <= '0;
            bit_cnt <= '0;
        end else if (cs_fall || cs_rise) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
        end else if (cs_low && sclk_rise) begin
            rx_sh   <= rx_byte[BYTE_W-2:0];
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end else if (cs_low && sclk_fall) begin
            // a falling edge with the bit counter at zero starts a new slot
            tx_sh <= (bit_cnt == '0) ? tx_byte : {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end

    // R1: MISO stays low while chip select is high
    p_miso_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_low && $past(!cs_low)) |-> !miso);

    // R8: a chip-select rise clears the bit position
    p_bitcnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (bit_cnt == '0));

endmodule

// File: rtl/spi_frame_buf.sv
module spi_frame_buf #(
    parameter  int DEPTH  = 128,
    parameter  int BYTE_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [BYTE_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [BYTE_W-1:0] rdata_b
);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_frame_pkg::*;
#(
    parameter  int BUF_DEPTH = 128,
    localparam int ADDR_W    = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] buf_rdata,
    input  logic              hst_buf_we,
    input  logic [ADDR_W-1:0] hst_buf_addr,
    input  logic              hst_meta_we,
    input  logic [1:0]        hst_meta_sel,
    input  logic [BYTE_W-1:0] hst_wdata,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_waddr,
    output logic [BYTE_W-1:0] buf_wdata,
    output logic [ADDR_W-1:0] buf_raddr,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] frm_len,
    output logic              tx_ready
);

    localparam logic [BYTE_W-1:0] TRAIL_LAST = BYTE_W'(2);

    fsm_state_t        state, nxt;
    logic [BYTE_W-1:0] cnt;
    logic [BYTE_W-1:0] len_q, lqi_q, ed_q, stat_q;
    logic              spi_we;
    logic              in_buf;

    assign in_buf = int'(cnt) < BUF_DEPTH;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        if (cs_rise) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cs_fall) nxt = ST_CMD;
                end
                ST_CMD: begin
                    if (byte_done) begin
                        if (rx_byte[BYTE_W-1 -: 3] == OP_FRAME_WR)      nxt = ST_WR_LEN;
                        else if (rx_byte[BYTE_W-1 -: 3] == OP_FRAME_RD) nxt = ST_RD_LEN;
                        else                                             nxt = ST_DRAIN;
                    end
                end
                ST_WR_LEN: begin
                    if (byte_done) nxt = ST_WR_DATA;
                end
                ST_WR_DATA: nxt = ST_WR_DATA;
                ST_RD_LEN: begin
                    if (byte_done) nxt = (len_q == '0) ? ST_RD_TRAIL : ST_RD_DATA;
                end
                ST_RD_DATA: begin
                    if (byte_done && (cnt == len_q - 1'b1)) nxt = ST_RD_TRAIL;
                end
                ST_RD_TRAIL: begin
                    if (byte_done && (cnt == TRAIL_LAST)) nxt = ST_DRAIN;
                end
                ST_DRAIN: nxt = ST_DRAIN;
            endcase
        end
    end

    // slot counter and quality fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            len_q    <= '0;
            lqi_q    <= '0;
            ed_q     <= '0;
            stat_q   <= '0;
            tx_ready <= 1'b0;
        end else begin
            tx_ready <= cs_rise && (state == ST_WR_DATA) && (cnt >= len_q);
            if (cs_fall || cs_rise) begin
                cnt <= '0;
            end else if (byte_done) begin
                unique case (state)
                    ST_WR_DATA:  cnt <= (cnt == '1) ? cnt : cnt + 1'b1;
                    ST_RD_LEN:   cnt <= '0;
                    ST_RD_DATA:  cnt <= (cnt == len_q - 1'b1) ? '0 : cnt + 1'b1;
                    ST_RD_TRAIL: cnt <= cnt + 1'b1;
                    default:     cnt <= cnt;
                endcase
            end
            if (!cs_rise && byte_done && state == ST_WR_LEN) begin
                len_q <= rx_byte;
            end else if (hst_meta_we && hst_meta_sel == META_LEN) begin
                len_q <= hst_wdata;
            end
            if (hst_meta_we && hst_meta_sel == META_LQI)  lqi_q  <= hst_wdata;
            if (hst_meta_we && hst_meta_sel == META_ED)   ed_q   <= hst_wdata;
            if (hst_meta_we && hst_meta_sel == META_STAT) stat_q <= hst_wdata;
        end
    end

    // byte for the slot now being shifted out
    always_comb begin
        tx_byte = '0;
        unique case (state)
            ST_RD_LEN:   tx_byte = len_q;
            ST_RD_DATA:  tx_byte = in_buf ? buf_rdata : '0;
            ST_RD_TRAIL: begin
                if (cnt == '0)             tx_byte = lqi_q;
                else if (cnt == BYTE_W'(1)) tx_byte = ed_q;
                else                        tx_byte = stat_q;
            end
            default:     tx_byte = '0;
        endcase
    end

    // buffer write port: the SPI side wins a same-cycle collision
    assign spi_we    = !cs_rise && byte_done && (state == ST_WR_DATA)
                       && (cnt < len_q) && in_buf;
    assign buf_we    = spi_we || hst_buf_we;
    assign buf_waddr = spi_we ? cnt[ADDR_W-1:0] : hst_buf_addr;
    assign buf_wdata = spi_we ? rx_byte : hst_wdata;
    assign buf_raddr = cnt[ADDR_W-1:0];
    assign frm_len   = len_q;

    // R2: the first byte after a chip-select fall is treated as a command
    p_cmd_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && !cs_rise) |=> (state == ST_CMD));

    // R4: the length byte of a write lands in the length field
    p_len_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_LEN && byte_done && !cs_rise) |=> (len_q == $past(rx_byte)));

    // R6: the payload of a read starts at address zero
    p_rd_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_LEN && byte_done && !cs_rise && len_q != '0)
        |=> (state == ST_RD_DATA && cnt == '0));

    // R7: the trailer never indexes past its third byte
    p_trail_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_TRAIL) |-> (cnt <= TRAIL_LAST));

    // R8: chip select rising always returns to idle
    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (state == ST_IDLE));

    // R10: the ready strobe is a single cycle and follows a write
    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);
    p_ready_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> ($past(state) == ST_WR_DATA));

    // R11: an empty frame goes straight from length to trailer
    p_empty_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_LEN && byte_done && !cs_rise && len_q == '0)
        |=> (state == ST_RD_TRAIL && cnt == '0));

endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
    import spi_frame_pkg::*;
#(
    parameter  int BUF_DEPTH   = 128,
    parameter  int SYNC_STAGES = 2,
    localparam int ADDR_W      = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              hst_buf_we,
    input  logic [ADDR_W-1:0] hst_buf_addr,
    input  logic              hst_meta_we,
    input  logic [1:0]        hst_meta_sel,
    input  logic [BYTE_W-1:0] hst_wdata,
    input  logic [ADDR_W-1:0] tx_rd_addr,
    output logic [BYTE_W-1:0] tx_rd_data,
    output logic [BYTE_W-1:0] frm_len,
    output logic              tx_ready
);

    logic              sclk_rise, sclk_fall, cs_fall, cs_rise, cs_low, mosi_s;
    logic [BYTE_W-1:0] rx_byte, tx_byte, buf_rdata, buf_wdata;
    logic              byte_done, buf_we;
    logic [ADDR_W-1:0] buf_waddr, buf_raddr;

    spi_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (spi_sclk),
        .cs_n_in   (spi_cs_n),
        .mosi_in   (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .cs_low    (cs_low),
        .mosi_s    (mosi_s)
    );

    spi_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_low    (cs_low),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .tx_byte   (tx_byte),
        .rx_byte   (rx_byte),
        .byte_done (byte_done),
        .miso      (spi_miso)
    );

    spi_frame_ctrl #(.BUF_DEPTH(BUF_DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_fall      (cs_fall),
        .cs_rise      (cs_rise),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .buf_rdata    (buf_rdata),
        .hst_buf_we   (hst_buf_we),
        .hst_buf_addr (hst_buf_addr),
        .hst_meta_we  (hst_meta_we),
        .hst_meta_sel (hst_meta_sel),
        .hst_wdata    (hst_wdata),
        .buf_we       (buf_we),
        .buf_waddr    (buf_waddr),
        .buf_wdata    (buf_wdata),
        .buf_raddr    (buf_raddr),
        .tx_byte      (tx_byte),
        .frm_len      (frm_len),
        .tx_ready     (tx_ready)
    );

    spi_frame_buf #(.DEPTH(BUF_DEPTH), .BYTE_W(BYTE_W)) u_buf (
        .clk     (clk),
        .we      (buf_we),
        .waddr   (buf_waddr),
        .wdata   (buf_wdata),
        .raddr_a (buf_raddr),
        .rdata_a (buf_rdata),
        .raddr_b (tx_rd_addr),
        .rdata_b (tx_rd_data)
    );

endmodule

// File: tb/spi_frame_slave_tb.sv
module spi_frame_slave_tb;

    localparam int HP = 6;

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] lqi;
        logic [7:0] ed;
        logic [7:0] st;
        logic [7:0] seed;
    } rd_vec_t;

    localparam rd_vec_t RD_VEC [4] = '{
        '{8'd3,   8'h11, 8'h22, 8'h33, 8'h40},
        '{8'd0,   8'h9A, 8'h5B, 8'hC3, 8'h00},
        '{8'd1,   8'hFF, 8'h00, 8'h81, 8'h7E},
        '{8'd127, 8'h01, 8'h80, 8'h3C, 8'hA5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic       hst_buf_we = 1'b0, hst_meta_we = 1'b0;
    logic [6:0] hst_buf_addr = '0, tx_rd_addr = '0;
    logic [1:0] hst_meta_sel = '0;
    logic [7:0] hst_wdata = '0;
    logic [7:0] tx_rd_data, frm_len;
    logic       tx_ready;

    int n_chk = 0, n_err = 0, rdy_cnt = 0;
    logic [7:0] mo [0:199];
    logic [7:0] mi [0:199];

    always #5 clk = ~clk;

    spi_frame_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .hst_buf_we(hst_buf_we),
        .hst_buf_addr(hst_buf_addr), .hst_meta_we(hst_meta_we),
        .hst_meta_sel(hst_meta_sel), .hst_wdata(hst_wdata),
        .tx_rd_addr(tx_rd_addr), .tx_rd_data(tx_rd_data),
        .frm_len(frm_len), .tx_ready(tx_ready)
    );

    always @(posedge clk) if (rst_n && tx_ready) rdy_cnt = rdy_cnt + 1;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_buf(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_buf_we = 1'b1; hst_buf_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_buf_we = 1'b0;
    endtask

    task automatic host_meta(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        hst_meta_we = 1'b1; hst_meta_sel = s; hst_wdata = d;
        @(negedge clk);
        hst_meta_we = 1'b0;
    endtask

    task automatic host_rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        tx_rd_addr = a;
        #1 d = tx_rd_data;
    endtask

    task automatic half();
        repeat (HP) @(negedge clk);
    endtask

    // n full bytes, then cut loose bits, then chip select high
    task automatic spi_run(input int n, input int cut);
        spi_cs_n = 1'b0;
        for (int b = 0; b < n; b++) begin
            for (int k = 7; k >= 0; k--) begin
                spi_mosi = mo[b][k];
                half();
                mi[b][k] = spi_miso;
                spi_sclk = 1'b1;
                half();
                spi_sclk = 1'b0;
            end
        end
        for (int k = 0; k < cut; k++) begin
            spi_mosi = ~spi_mosi;
            half();
            spi_sclk = 1'b1;
            half();
            spi_sclk = 1'b0;
        end
        half();
        spi_cs_n = 1'b1;
        half(); half();
    endtask

    function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
        return seed + 8'(i * 13);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d, e;
        int r0, n, ln;
        string tag;

        // R1: reset values
        repeat (3) @(negedge clk);
        chk("R1 miso in reset", {7'd0, spi_miso}, 8'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 miso", {7'd0, spi_miso}, 8'd0);
        chk("R1 tx_ready", {7'd0, tx_ready}, 8'd0);
        chk("R1 frm_len", frm_len, 8'd0);

        // frame read table, loaded through the host port (R9)
        for (int v = 0; v < 4; v++) begin
            ln = int'(RD_VEC[v].len);
            host_meta(2'd0, RD_VEC[v].len);
            host_meta(2'd1, RD_VEC[v].lqi);
            host_meta(2'd2, RD_VEC[v].ed);
            host_meta(2'd3, RD_VEC[v].st);
            for (int i = 0; i < ln; i++) host_buf(7'(i), pay(RD_VEC[v].seed, i));
            n = ln + 7;
            mo[0] = 8'h20 | 8'(v);
            for (int i = 1; i < n; i++) mo[i] = 8'hFF;
            spi_run(n, 0);
            for (int s = 0; s < n; s++) begin
                if (s == 0)            begin e = 8'h00;              tag = "R2 command slot"; end
                else if (s == 1)       begin e = RD_VEC[v].len;      tag = "R6 length slot"; end
                else if (s < ln + 2)   begin e = pay(RD_VEC[v].seed, s - 2); tag = "R6 payload"; end
                else if (s == ln + 2)  begin e = RD_VEC[v].lqi;      tag = (ln == 0) ? "R11 lqi" : "R7 lqi"; end
                else if (s == ln + 3)  begin e = RD_VEC[v].ed;       tag = "R7 energy"; end
                else if (s == ln + 4)  begin e = RD_VEC[v].st;       tag = "R7 status"; end
                else                   begin e = 8'h00;              tag = "R7 after trailer"; end
                chk($sformatf("%s vec%0d slot%0d", tag, v, s), mi[s], e);
            end
        end
        host_rd(7'd0, d);
        chk("R9 host buffer read", d, 8'hA5);
        chk("R9 host length", frm_len, 8'd127);

        // frame write with two extra bytes beyond the length
        host_buf(7'd4, 8'h5A);
        r0 = rdy_cnt;
        mo[0] = 8'h60; mo[1] = 8'd4;
        for (int i = 0; i < 6; i++) mo[2+i] = 8'hA0 + 8'(i);
        spi_run(8, 0);
        chk("R4 written length", frm_len, 8'd4);
        for (int i = 0; i < 4; i++) begin
            host_rd(7'(i), d);
            chk($sformatf("R4 payload addr%0d", i), d, 8'hA0 + 8'(i));
        end
        host_rd(7'd4, d);
        chk("R5 byte past length discarded", d, 8'h5A);
        for (int s = 0; s < 8; s++) chk($sformatf("R3 write miso slot%0d", s), mi[s], 8'h00);
        chk("R10 ready after full write", 8'(rdy_cnt - r0), 8'd1);

        // read back the written frame
        mo[0] = 8'h20;
        spi_run(6, 0);
        chk("R6 readback length", mi[1], 8'd4);
        for (int i = 0; i < 4; i++) chk($sformatf("R6 readback %0d", i), mi[2+i], 8'hA0 + 8'(i));

        // ignored opcodes
        for (int c = 0; c < 2; c++) begin
            r0 = rdy_cnt;
            mo[0] = (c == 0) ? 8'hE0 : 8'h40; mo[1] = 8'h02; mo[2] = 8'h11; mo[3] = 8'h22;
            spi_run(4, 0);
            for (int s = 0; s < 4; s++) chk($sformatf("R3 ignored miso op%0d slot%0d", c, s), mi[s], 8'h00);
            chk("R3 ignored keeps length", frm_len, 8'd4);
            host_rd(7'd0, d);
            chk("R3 ignored keeps buffer", d, 8'hA0);
            chk("R3 ignored no ready", 8'(rdy_cnt - r0), 8'd0);
        end

        // overflow: length 200, 130 payload bytes
        r0 = rdy_cnt;
        mo[0] = 8'h7F; mo[1] = 8'd200;
        for (int i = 0; i < 130; i++) mo[2+i] = 8'(i) + 8'h10;
        spi_run(132, 0);
        chk("R4 long length", frm_len, 8'd200);
        host_rd(7'd0, d);
        chk("R5 no wrap at addr0", d, 8'h10);
        host_rd(7'd127, d);
        chk("R5 last slot stored", d, 8'h8F);
        chk("R10 short write no ready", 8'(rdy_cnt - r0), 8'd0);

        // write aborted in the middle of a byte
        r0 = rdy_cnt;
        mo[0] = 8'h60; mo[1] = 8'd9; mo[2] = 8'h31; mo[3] = 8'h32;
        spi_run(4, 3);
        chk("R10 aborted write no ready", 8'(rdy_cnt - r0), 8'd0);
        chk("R8 aborted write length", frm_len, 8'd9);
        host_rd(7'd1, d);
        chk("R8 aborted write byte1", d, 8'h32);
        host_rd(7'd2, d);
        chk("R8 partial byte not stored", d, 8'h12);
        mo[0] = 8'h20;
        spi_run(4, 0);
        chk("R8 fresh read length", mi[1], 8'd9);
        chk("R8 fresh read byte0", mi[2], 8'h31);

        // read aborted mid payload, then a new read
        mo[0] = 8'h20;
        spi_run(3, 4);
        spi_run(3, 0);
        chk("R8 restart after read abort", mi[1], 8'd9);
        chk("R8 restart payload", mi[2], 8'h31);

        // zero-length write completes at once
        r0 = rdy_cnt;
        mo[0] = 8'h60; mo[1] = 8'd0;
        spi_run(2, 0);
        chk("R10 empty write ready", 8'(rdy_cnt - r0), 8'd1);
        chk("R4 empty length", frm_len, 8'd0);

        summary();
        $finish;
    end

endmodule